// File: doc/BRIEF.md
# Buffered SPI Master Controller

This block is an SPI master with two four-entry frame queues. A simple register port (write enable, read enable, a two-bit address, 32-bit data) connects it to a host. Frames written to the data register wait in the transmit queue. The serial engine takes the oldest waiting frame when it is free, or in the same cycle that the current frame ends, so frames queued back to back go out without a gap. Each frame the engine clocks in is placed in the receive queue. The host reads the data register to remove received frames from that queue.

A status register reports four things: a sticky overrun flag that is set when the host writes to a full transmit queue, a live idle flag, and two fill indications compared against programmable levels. Four enable bits mask these four conditions. The masked conditions form three interrupt sources (error or idle, receive fill, transmit fill), and these are ORed onto a single interrupt line.

Register map, with all unlisted bits reading zero:
- Address 0 is the data register. A write queues bits [7:0]. A read returns the oldest received frame and removes it.
- Address 1 is the control register, read/write. Bit 0 enables the overrun interrupt, bit 1 the idle interrupt, bit 2 the receive-fill interrupt and bit 3 the transmit-fill interrupt. Bits [6:4] hold the receive level and bits [10:8] the transmit level. Bits [23:16] hold the clock divider D.
- Address 2 is the status register. Bit 0 is overrun (write 1 to clear), bit 1 is idle, bit 2 is receive fill and bit 3 is transmit fill. Bits [6:4] hold the receive count and bits [10:8] the transmit count.
- Address 3 reads zero.

Top module: `spim_ctrl`

## Requirements
- R1: Each write to address 0 queues bits [7:0] in a 4-entry transmit queue. Frames are sent in the order they were written.
- R2: A frame is 8 bits, sent MSB first in mode 0. MOSI is valid before the first rising SCLK edge. MISO is sampled on rising edges. SCLK is low whenever no frame is in progress. Each SCLK half period lasts D+1 system clocks.
- R3: cs_n is low exactly while a frame is in progress. When a frame ends and the transmit queue is not empty, the next frame starts in the same cycle, so two queued frames hold cs_n low for exactly 32*(D+1) clocks.
- R4: Each completed frame is placed in a 4-entry receive queue. Reads of address 0 return received frames in arrival order, in bits [7:0]. A frame that arrives while the receive queue is full is dropped.
- R5: Reading address 0 while the receive queue is empty returns 0 and changes nothing.
- R6: A write to address 0 while the transmit queue holds 4 frames is discarded: the queue keeps its contents and count, and status bit 0 (overrun) becomes 1.
- R7: Overrun stays set until the host writes status with bit 0 = 1. Writing bit 0 = 0 leaves it set.
- R8: Status bit 1 (idle) is 1 exactly when the transmit queue is empty and no frame is in progress.
- R9: A level of 0 acts as 1 and a level above 4 acts as 4. Status bit 2 is 1 when the receive count is at or above the effective receive level. Status bit 3 is 1 when the number of free transmit entries is at or above the effective transmit level.
- R10: irq is the OR of (overrun AND bit 0 of control), (idle AND bit 1), (receive fill AND bit 2) and (transmit fill AND bit 3).
- R11: After reset, control reads 0 and status reads 0x0000000A: idle and transmit fill set, everything else clear. irq is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (pops the receive queue at address 0) |
| addr | input | 2 | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for the current address |
| irq | output | 1 | Combined interrupt |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Active-low select, low during a frame |

## Verification
A serial device model in the bench does two things: it records every MOSI bit on rising SCLK edges, and it drives MISO from a known byte sequence. Random bursts of one to four frames at random divider values check queue order, bit order and receive data together. A byte sent LSB first, or sampled on the wrong edge, produces different values in these checks. Directed cases test the following:
- six writes in a row against a slow clock, which separates a dropped sixth frame from a corrupted queue;
- five frames against a 4-entry receive queue;
- reads of an empty queue;
- the write-1-to-clear rule, checked with both 0 and 1 written to bit 0;
- level clamping at 0 and at 7;
- the exact cs_n low time for two back-to-back frames, which tells a seamless handoff from one that inserts idle cycles.

// File: rtl/spim_pkg.sv
package spim_pkg;

    parameter int BUS_W   = 32;
    parameter int FRAME_W = 8;
    parameter int DEPTH   = 4;
    parameter int DIV_W   = 8;
    parameter int LVL_W   = 3;
    localparam int CNT_W  = $clog2(DEPTH + 1);

    typedef logic [1:0] reg_addr_t;
    localparam reg_addr_t ADDR_DATA = 2'd0;
    localparam reg_addr_t ADDR_CTRL = 2'd1;
    localparam reg_addr_t ADDR_STAT = 2'd2;

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic [LVL_W-1:0] tx_lvl;
        logic [LVL_W-1:0] rx_lvl;
        logic             txf_ie;
        logic             rxf_ie;
        logic             idle_ie;
        logic             ovr_ie;
    } ctrl_t;

    typedef struct packed {
        logic [CNT_W-1:0] tx_cnt;
        logic [CNT_W-1:0] rx_cnt;
        logic             txf;
        logic             rxf;
        logic             idle;
        logic             ovr;
    } stat_t;

    function automatic logic [CNT_W-1:0] eff_level(input logic [LVL_W-1:0] lvl);
        if (lvl == '0)
            return CNT_W'(1);
        else if (32'(lvl) > DEPTH)
            return CNT_W'(DEPTH);
        else
            return CNT_W'(lvl);
    endfunction

endpackage

// File: rtl/spim_fifo.sv
module spim_fifo
    import spim_pkg::*;
#(
    parameter int W = FRAME_W,
    parameter int N = DEPTH
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       push,
    input  logic [W-1:0]               din,
    input  logic                       pop,
    output logic [W-1:0]               dout,
    output logic [$clog2(N+1)-1:0]     count,
    output logic                       full,
    output logic                       empty
);
    localparam int PW = (N > 1) ? $clog2(N) : 1;
    localparam int CW = $clog2(N + 1);

    logic [W-1:0]  mem [N];
    logic [PW-1:0] wptr, rptr;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (32'(p) == N - 1) ? '0 : p + PW'(1);
    endfunction

    assign full  = (32'(count) == N);
    assign empty = (count == '0);
    assign dout  = mem[rptr];

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (push) begin
                mem[wptr] <= din;
                wptr      <= bump(wptr);
            end
            if (pop)
                rptr <= bump(rptr);
            if (push && !pop)
                count <= count + CW'(1);
            else if (pop && !push)
                count <= count - CW'(1);
        end
    end

    AST_PUSH_NOT_FULL: assert property (@(posedge clk) disable iff (rst)
        push |-> (!full || pop)); // R6
    AST_POP_NOT_EMPTY: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty); // R5

endmodule

// File: rtl/spim_shift.sv
module spim_shift
    import spim_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [DIV_W-1:0]   div,
    input  logic               start,
    input  logic [FRAME_W-1:0] load,
    input  logic               miso,
    output logic               busy,
    output logic               done,
    output logic               sclk,
    output logic               mosi,
    output logic [FRAME_W-1:0] rx_data
);
    localparam int BW = $clog2(FRAME_W);
    localparam logic [BW-1:0] LAST = BW'(FRAME_W - 1);

    logic [DIV_W-1:0]   div_cnt;
    logic [BW-1:0]      bit_cnt;
    logic [FRAME_W-1:0] tx_sh, rx_sh;
    logic               tick;

    assign tick    = busy && (div_cnt == div);
    assign done    = tick && sclk && (bit_cnt == LAST);
    assign mosi    = busy ? tx_sh[FRAME_W-1] : 1'b0;
    assign rx_data = rx_sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            sclk    <= 1'b0;
            div_cnt <= '0;
            bit_cnt <= '0;
            tx_sh   <= '0;
            rx_sh   <= '0;
        end else if (start) begin
            busy    <= 1'b1;
            sclk    <= 1'b0;
            div_cnt <= '0;
            bit_cnt <= '0;
            tx_sh   <= load;
        end else if (busy) begin
            if (tick) begin
                div_cnt <= '0;
                sclk    <= ~sclk;
                if (!sclk) begin
                    rx_sh <= {rx_sh[FRAME_W-2:0], miso};
                end else if (bit_cnt == LAST) begin
                    busy <= 1'b0;
                end else begin
                    bit_cnt <= bit_cnt + BW'(1);
                    tx_sh   <= {tx_sh[FRAME_W-2:0], 1'b0};
                end
            end else begin
                div_cnt <= div_cnt + DIV_W'(1);
            end
        end
    end

    AST_START_WHEN_FREE: assert property (@(posedge clk) disable iff (rst)
        start |-> (!busy || done)); // R3
    AST_SCLK_LOW_IDLE: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !sclk); // R2

endmodule

// File: rtl/spim_ctrl.sv
module spim_ctrl
    import spim_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [1:0]       addr,
    input  logic [BUS_W-1:0] wdata,
    output logic [BUS_W-1:0] rdata,
    output logic             irq,
    output logic             sclk,
    output logic             mosi,
    input  logic             miso,
    output logic             cs_n
);
    ctrl_t              ctrl;
    stat_t              stat;
    logic               ovr;
    logic               wr_data, wr_stat, rd_data;
    logic               tx_push, tx_pop, tx_full, tx_empty;
    logic               rx_push, rx_pop, rx_full, rx_empty;
    logic [CNT_W-1:0]   tx_cnt, rx_cnt;
    logic [FRAME_W-1:0] tx_head, rx_head, rx_frame;
    logic               busy, done;

    assign wr_data = wr_en && (addr == ADDR_DATA);
    assign wr_stat = wr_en && (addr == ADDR_STAT);
    assign rd_data = rd_en && (addr == ADDR_DATA);

    assign tx_push = wr_data && !tx_full;
    assign tx_pop  = !tx_empty && (!busy || done);
    assign rx_push = done && !rx_full;
    assign rx_pop  = rd_data && !rx_empty;

    spim_fifo #(.W(FRAME_W), .N(DEPTH)) u_txq (
        .clk(clk), .rst(rst),
        .push(tx_push), .din(wdata[FRAME_W-1:0]),
        .pop(tx_pop), .dout(tx_head),
        .count(tx_cnt), .full(tx_full), .empty(tx_empty)
    );

    spim_fifo #(.W(FRAME_W), .N(DEPTH)) u_rxq (
        .clk(clk), .rst(rst),
        .push(rx_push), .din(rx_frame),
        .pop(rx_pop), .dout(rx_head),
        .count(rx_cnt), .full(rx_full), .empty(rx_empty)
    );

    spim_shift u_eng (
        .clk(clk), .rst(rst), .div(ctrl.div),
        .start(tx_pop), .load(tx_head), .miso(miso),
        .busy(busy), .done(done), .sclk(sclk), .mosi(mosi),
        .rx_data(rx_frame)
    );

    assign cs_n = !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
            ovr  <= 1'b0;
        end else begin
            if (wr_en && (addr == ADDR_CTRL)) begin
                ctrl.ovr_ie  <= wdata[0];
                ctrl.idle_ie <= wdata[1];
                ctrl.rxf_ie  <= wdata[2];
                ctrl.txf_ie  <= wdata[3];
                ctrl.rx_lvl  <= wdata[4 +: LVL_W];
                ctrl.tx_lvl  <= wdata[8 +: LVL_W];
                ctrl.div     <= wdata[16 +: DIV_W];
            end
            if (wr_data && tx_full)
                ovr <= 1'b1;
            else if (wr_stat && wdata[0])
                ovr <= 1'b0;
        end
    end

    always_comb begin
        stat.ovr    = ovr;
        stat.idle   = tx_empty && !busy;
        stat.rxf    = rx_cnt >= eff_level(ctrl.rx_lvl);
        stat.txf    = (CNT_W'(DEPTH) - tx_cnt) >= eff_level(ctrl.tx_lvl);
        stat.rx_cnt = rx_cnt;
        stat.tx_cnt = tx_cnt;
    end

    assign irq = (stat.ovr && ctrl.ovr_ie) || (stat.idle && ctrl.idle_ie) ||
                 (stat.rxf && ctrl.rxf_ie) || (stat.txf && ctrl.txf_ie);

    always_comb begin
        rdata = '0;
        unique case (addr)
            ADDR_DATA: if (!rx_empty) rdata[FRAME_W-1:0] = rx_head;
            ADDR_CTRL: begin
                rdata[0]            = ctrl.ovr_ie;
                rdata[1]            = ctrl.idle_ie;
                rdata[2]            = ctrl.rxf_ie;
                rdata[3]            = ctrl.txf_ie;
                rdata[4 +: LVL_W]   = ctrl.rx_lvl;
                rdata[8 +: LVL_W]   = ctrl.tx_lvl;
                rdata[16 +: DIV_W]  = ctrl.div;
            end
            ADDR_STAT: begin
                rdata[0]            = stat.ovr;
                rdata[1]            = stat.idle;
                rdata[2]            = stat.rxf;
                rdata[3]            = stat.txf;
                rdata[4 +: CNT_W]   = stat.rx_cnt;
                rdata[8 +: CNT_W]   = stat.tx_cnt;
            end
            default: rdata = '0;
        endcase
    end

    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (rst)
        (ovr && !(wr_stat && wdata[0])) |=> ovr); // R7
    AST_OVR_ON_FULL: assert property (@(posedge clk) disable iff (rst)
        (wr_data && tx_full) |=> ovr); // R6
    AST_TX_HELD_ON_DROP: assert property (@(posedge clk) disable iff (rst)
        (wr_data && tx_full && !tx_pop) |=> (tx_cnt == $past(tx_cnt))); // R6
    AST_CS_MATCH_SCLK: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> !sclk); // R3

endmodule

// File: tb/spim_ctrl_test.sv
module spim_ctrl_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en, rd_en;
    logic [1:0]  addr;
    logic [31:0] wdata, rdata;
    logic        irq, sclk, mosi, miso, cs_n;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spim_ctrl uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .irq(irq), .sclk(sclk), .mosi(mosi),
        .miso(miso), .cs_n(cs_n)
    );

    // serial device model
    logic [7:0] mo_log [0:1023];
    logic [7:0] mo_sh = 8'h00;
    int mo_n   = 0;
    int sl_bit = 0;
    int sl_idx = 0;

    function automatic logic [7:0] sl_pat(input int k);
        return 8'((k * 37 + 91) & 8'hFF);
    endfunction

    always_comb miso = (sl_pat(sl_idx) >> (7 - sl_bit)) & 8'h01;

    always @(posedge sclk) begin
        mo_sh = {mo_sh[6:0], mosi};
        sl_bit = sl_bit + 1;
        if (sl_bit == 8) begin
            mo_log[mo_n] = mo_sh;
            mo_n   = mo_n + 1;
            sl_bit = 0;
            sl_idx = sl_idx + 1;
        end
    end

    int cs_low = 0;
    int sclk_hi = 0;
    always @(negedge clk) begin
        if (cs_n === 1'b0) cs_low = cs_low + 1;
        if (sclk === 1'b1) sclk_hi = sclk_hi + 1;
    end

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] v);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        #1 v = rdata;
        @(posedge clk); #1;
        rd_en = 1'b0;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        v = 32'h0;
        while (!v[1]) rd(2'd2, v);
        while (cs_n !== 1'b1) @(negedge clk);
    endtask

    function automatic logic [31:0] ctrl_word(input int ie, input int rxl, input int txl, input int dv);
        return 32'(ie & 15) | (32'(rxl & 7) << 4) | (32'(txl & 7) << 8) | (32'(dv & 255) << 16);
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [7:0]  sent [0:7];
        int base, mbase, n, dv;

        void'($urandom(32'd4711));
        rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0; addr = 2'd0; wdata = '0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R11 reset state
        rd(2'd2, v); chk(v, 32'h0000000A, "R11 status after reset");
        rd(2'd1, v); chk(v, 32'h0, "R11 control after reset");
        chk({31'b0, irq}, 32'h0, "R11 irq after reset");

        // R5 empty read
        rd(2'd0, v); chk(v, 32'h0, "R5 empty data read");
        rd(2'd2, v); chk(v, 32'h0000000A, "R5 status unchanged after empty read");

        // R6 overrun with slow clock, R4 receive drop
        wr(2'd1, ctrl_word(0, 1, 1, 20));
        base = sl_idx; mbase = mo_n;
        for (int i = 0; i < 6; i++) begin
            sent[i] = 8'(8'hA0 + i * 7);
            wr(2'd0, {24'h0, sent[i]});
        end
        rd(2'd2, v);
        chk(v & 32'h701, 32'h401, "R6 overrun set, tx count stays 4");
        chk({31'b0, v[1]}, 32'h0, "R8 idle low while busy");
        wr(2'd2, 32'h0);
        rd(2'd2, v); chk({31'b0, v[0]}, 32'h1, "R7 write 0 keeps overrun");
        wr(2'd2, 32'h1);
        rd(2'd2, v); chk({31'b0, v[0]}, 32'h0, "R7 write 1 clears overrun");
        wait_idle();
        chk(mo_n - mbase, 5, "R6 five frames sent, sixth dropped");
        for (int i = 0; i < 5; i++)
            chk({24'h0, mo_log[mbase + i]}, {24'h0, sent[i]}, "R1 R2 frame order and bit order");
        rd(2'd2, v); chk(v & 32'h72, 32'h42, "R4 rx count 4 and R8 idle");
        for (int i = 0; i < 4; i++) begin
            rd(2'd0, v); chk(v, {24'h0, sl_pat(base + i)}, "R4 received frame");
        end
        rd(2'd0, v); chk(v, 32'h0, "R4 fifth frame dropped, R5 empty read");

        // R3 back-to-back timing and R2 SCLK rate
        wr(2'd1, ctrl_word(0, 1, 1, 1));
        cs_low = 0; sclk_hi = 0;
        wr(2'd0, 32'h5A);
        wr(2'd0, 32'hC3);
        wait_idle();
        chk(cs_low, 64, "R3 cs_n low cycles for two frames");
        chk(sclk_hi, 32, "R2 sclk high cycles for two frames");
        rd(2'd0, v); rd(2'd0, v);

        // R9 R10 receive fill
        wr(2'd1, ctrl_word(4, 2, 1, 0));
        wr(2'd0, 32'h11); wait_idle(); @(negedge clk);
        chk({31'b0, irq}, 32'h0, "R10 rx fill below level");
        wr(2'd0, 32'h22); wait_idle(); @(negedge clk);
        chk({31'b0, irq}, 32'h1, "R10 rx fill at level");
        rd(2'd2, v); chk({31'b0, v[2]}, 32'h1, "R9 rx fill status");
        rd(2'd0, v); rd(2'd0, v);
        @(negedge clk); chk({31'b0, irq}, 32'h0, "R10 rx fill cleared by reads");

        // R10 idle and overrun masks
        wr(2'd1, ctrl_word(2, 1, 1, 0)); @(negedge clk);
        chk({31'b0, irq}, 32'h1, "R10 idle source");
        wr(2'd1, ctrl_word(1, 1, 1, 0)); @(negedge clk);
        chk({31'b0, irq}, 32'h0, "R10 overrun source clear");

        // R9 transmit fill with clamped levels
        wr(2'd1, ctrl_word(8, 1, 7, 50)); @(negedge clk);
        chk({31'b0, irq}, 32'h1, "R9 level 7 acts as 4, all free");
        wr(2'd0, 32'h01); wr(2'd0, 32'h02); wr(2'd0, 32'h03);
        rd(2'd2, v); chk({31'b0, v[3]}, 32'h0, "R9 tx level 4 with 2 free");
        wr(2'd1, ctrl_word(8, 1, 2, 50));
        rd(2'd2, v); chk({31'b0, v[3]}, 32'h1, "R9 tx level 2 with 2 free");
        wr(2'd1, ctrl_word(8, 1, 0, 50));
        rd(2'd2, v); chk({31'b0, v[3]}, 32'h1, "R9 level 0 acts as 1");
        wait_idle();
        for (int i = 0; i < 3; i++) rd(2'd0, v);

        // random bursts
        for (int it = 0; it < 20; it++) begin
            dv = int'($urandom % 4);
            n  = 1 + int'($urandom % 4);
            wr(2'd1, ctrl_word(0, 1, 1, dv));
            base = sl_idx; mbase = mo_n;
            for (int i = 0; i < n; i++) begin
                sent[i] = 8'($urandom);
                wr(2'd0, {24'h0, sent[i]});
            end
            wait_idle();
            for (int i = 0; i < n; i++) begin
                chk({24'h0, mo_log[mbase + i]}, {24'h0, sent[i]}, "R1 R2 random sent frame");
                rd(2'd0, v);
                chk(v, {24'h0, sl_pat(base + i)}, "R4 random received frame");
            end
            rd(2'd0, v); chk(v, 32'h0, "R5 queue empty after burst");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule